// File: doc/BRIEF.md
# Multi-channel PWM bank with shadowed settings

This block holds a row of identical pulse-width generators that share one clock. Each channel runs a 16-bit up-counter that restarts at a programmed period value. A clock prescaler selects how many input clocks make up one count. A window bounded by a start count and a stop count defines the active phase, and the rest of the period is the inactive phase. Each phase has its own two-bit output-state code, which sets both the pin level and the pin's output-enable. A phase can therefore drive high, drive low, or release the pin.

Software stages new settings through two write strobes that share one data bus and one channel index. A window write only fills a staging copy. The later period write arms the transfer of both staged words. On a running channel the transfer waits for the count to wrap, so the period in progress always finishes with the settings it started with. On a stopped channel the transfer happens on the next clock. The write strobes are plain control pins with no back-pressure: a strobe is accepted in the cycle it is high.

Top module: `pwm_bank`

## Requirements
- R1: After reset every channel has output-enable low and pin value low.
- R2: A running channel counts 0, 1, ... up to the period field (period word bits 15:0) and then wraps to 0. It is in its active phase while start <= count < stop, where start is window word bits 15:0 and stop is window word bits 31:16. At all other counts it is in its inactive phase.
- R3: The active-phase code sits in period word bits 17:16 and the inactive-phase code sits in bits 19:18. Code 3 drives the pin high and code 2 drives it low, both with output-enable high. Codes 0 and 1 give output-enable low, and the pin value then reads 0.
- R4: The prescaler code sits in period word bits 22:20. Codes 0 to 7 make each count last 2 to the power 0, 1, 2, 3, 4, 6, 8 and 10 clocks respectively.
- R5: A window write that is not followed by a period write never changes any channel output.
- R6: A period write on a running channel arms the staged window and period words. They take effect together at the next wrap of the count, and the period in progress completes with the old settings.
- R7: A stop value of 0 keeps the channel in its inactive phase for the whole period. A stop value larger than the period, with start 0, keeps it active for the whole period.
- R8: While a channel's enable is low, its output shows the inactive-phase code and its counter and prescaler stay at zero. When the enable rises, counting restarts from count 0.
- R9: On a disabled channel, armed settings load on the next clock edge.
- R10: A write addressed to one channel leaves every other channel's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_en | input | NUM_CH | Run enable, one bit per channel |
| wr_ch | input | CH_W | Channel index for a write |
| wr_active | input | 1 | Strobe: stage the window word |
| wr_period | input | 1 | Strobe: stage the period word and arm the transfer |
| wr_data | input | 32 | Write data |
| pwm_out | output | NUM_CH | Pin value per channel |
| pwm_oe | output | NUM_CH | Output-enable per channel |

## Verification
The hardest case to reach is a period write that lands in the middle of a running period, right after a window-only write, on a channel whose phase is not visible at the ports. The stimulus starts the channel from a known stopped state, so the bench knows the count at every clock. It issues the window write early in one period, lets several whole periods pass to show that nothing changes, and then issues the period write part way through a later period. It then checks the pin on every clock up to and past the next wrap.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int CNT_W   = 16;
  localparam int MAX_SHF = 10;
  localparam int PRE_W   = MAX_SHF;
  localparam int PER_W   = 3 + 2 + 2 + CNT_W;

  typedef struct packed {
    logic [CNT_W-1:0] stop;
    logic [CNT_W-1:0] start;
  } act_cfg_t;

  typedef struct packed {
    logic [2:0]       div_code;
    logic [1:0]       idle_code;
    logic [1:0]       busy_code;
    logic [CNT_W-1:0] period;
  } per_cfg_t;

  function automatic logic [3:0] div_shift(input logic [2:0] code);
    case (code)
      3'd5:    return 4'd6;
      3'd6:    return 4'd8;
      3'd7:    return 4'd10;
      default: return {1'b0, code};
    endcase
  endfunction
endpackage

// File: rtl/pwm_presc.sv
module pwm_presc
  import pwm_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic [3:0] shift_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pc_q;
  logic [PRE_W:0]   lim;

  always_comb begin
    lim    = ({{PRE_W{1'b0}}, 1'b1} << shift_i) - 1'b1;
    tick_o = run_i && (pc_q == lim[PRE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '0;
    else if (!run_i) pc_q <= '0;
    else if (tick_o) pc_q <= '0;
    else             pc_q <= pc_q + 1'b1;
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && shift_i != 4'd0) |=> (!tick_o || shift_i == 4'd0));
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_act_i,
  input  logic        wr_per_i,
  input  logic [31:0] wr_data_i,
  input  logic        commit_ok_i,
  output act_cfg_t    act_live_o,
  output per_cfg_t    per_live_o
);
  act_cfg_t act_sh_q;
  per_cfg_t per_sh_q;
  logic     pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sh_q   <= '0;
      per_sh_q   <= '0;
      act_live_o <= '0;
      per_live_o <= '0;
      pend_q     <= 1'b0;
    end else begin
      if (wr_act_i) act_sh_q <= act_cfg_t'(wr_data_i);
      if (wr_per_i) per_sh_q <= per_cfg_t'(wr_data_i[PER_W-1:0]);
      if (pend_q && commit_ok_i) begin
        act_live_o <= act_sh_q;
        per_live_o <= per_sh_q;
      end
      pend_q <= wr_per_i | (pend_q & ~commit_ok_i);
    end
  end

  // R5
  act_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act_i && !wr_per_i && !pend_q) |=> !pend_q);

  // R6
  commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_live_o) |-> ($past(pend_q) && $past(commit_ok_i)));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic        wr_act_i,
  input  logic        wr_per_i,
  input  logic [31:0] wr_data_i,
  output logic        pwm_out_o,
  output logic        pwm_oe_o
);
  act_cfg_t         act;
  per_cfg_t         per;
  logic             tick, wrap, commit_ok, in_win;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       code;

  pwm_shadow u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_act_i   (wr_act_i),
    .wr_per_i   (wr_per_i),
    .wr_data_i  (wr_data_i),
    .commit_ok_i(commit_ok),
    .act_live_o (act),
    .per_live_o (per)
  );

  pwm_presc u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (en_i),
    .shift_i(div_shift(per.div_code)),
    .tick_o (tick)
  );

  always_comb begin
    wrap      = tick && (cnt_q == per.period);
    commit_ok = wrap || !en_i;
    in_win    = (cnt_q >= act.start) && (cnt_q < act.stop);
    code      = (en_i && in_win) ? per.busy_code : per.idle_code;
    pwm_oe_o  = code[1];
    pwm_out_o = code[1] & code[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else if (tick)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q <= per.period));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));

  // R3
  hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per.busy_code[1] == 1'b0 && per.idle_code[1] == 1'b0) |-> (!pwm_oe_o && !pwm_out_o));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic              wr_active,
  input  logic              wr_period,
  input  logic [31:0]       wr_data,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pwm_oe
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = (wr_ch == CH_W'(g));

    pwm_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (ch_en[g]),
      .wr_act_i (wr_active && hit),
      .wr_per_i (wr_period && hit),
      .wr_data_i(wr_data),
      .pwm_out_o(pwm_out[g]),
      .pwm_oe_o (pwm_oe[g])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (pwm_oe == '0));
endmodule

// File: tb/pwm_bank_tb_top.sv
module pwm_bank_tb_top;
  localparam int NCH = 4;
  localparam int CHW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] ch_en = '0;
  logic [CHW-1:0] wr_ch = '0;
  logic           wr_active = 1'b0;
  logic           wr_period = 1'b0;
  logic [31:0]    wr_data = '0;
  logic [NCH-1:0] pwm_out, pwm_oe;
  int             vec_n = 0;
  int             bad_n = 0;

  always #4 clk = ~clk;

  pwm_bank #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .wr_ch(wr_ch),
    .wr_active(wr_active), .wr_period(wr_period), .wr_data(wr_data),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  function automatic logic [1:0] lvl(input logic [1:0] code);
    return code[1] ? {1'b1, code[0]} : 2'b00;
  endfunction

  function automatic logic [31:0] per_w(input int per, input logic [1:0] busy,
                                        input logic [1:0] idle, input logic [2:0] dc);
    return {9'd0, dc, idle, busy, 16'(per)};
  endfunction

  function automatic logic [31:0] win_w(input int start, input int stop);
    return {16'(stop), 16'(start)};
  endfunction

  task automatic chk(input int ch, input logic [1:0] exp, input string tag);
    logic [1:0] got;
    got = {pwm_oe[ch], pwm_out[ch]};
    vec_n++;
    if (got !== exp) begin
      bad_n++;
      $display("FAIL %s ch%0d oe/out got %b expected %b", tag, ch, got, exp);
    end
  endtask

  task automatic halt(input int ch);
    @(negedge clk);
    ch_en[ch] = 1'b0;
  endtask

  task automatic cfg(input int ch, input logic [31:0] aw, input logic [31:0] pw);
    @(negedge clk);
    wr_ch = CHW'(ch); wr_data = aw; wr_active = 1'b1;
    @(negedge clk);
    wr_active = 1'b0; wr_data = pw; wr_period = 1'b1;
    @(negedge clk);
    wr_period = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_pat(input int ch, input int start, input int stop, input int per,
                         input int shift, input logic [1:0] busy, input logic [1:0] idle,
                         input int n, input string tag);
    @(negedge clk);
    ch_en[ch] = 1'b1;
    for (int k = 0; k < n; k++) begin
      int c;
      if (k > 0) @(negedge clk);
      #1;
      c = (k >> shift) % (per + 1);
      chk(ch, (c >= start && c < stop) ? lvl(busy) : lvl(idle), tag);
    end
  endtask

  task automatic t_reset();
    for (int ch = 0; ch < NCH; ch++) chk(ch, 2'b00, "R1");
  endtask

  task automatic t_basic();
    cfg(0, win_w(0, 3), per_w(7, 2'd3, 2'd2, 3'd0));
    #1 chk(0, 2'b10, "R9");
    run_pat(0, 0, 3, 7, 0, 2'd3, 2'd2, 16, "R2");
    @(negedge clk);
    ch_en[0] = 1'b0;
    #1 chk(0, 2'b10, "R8");
    run_pat(0, 0, 3, 7, 0, 2'd3, 2'd2, 8, "R8");
  endtask

  task automatic t_window();
    halt(0);
    cfg(0, win_w(2, 5), per_w(7, 2'd3, 2'd2, 3'd0));
    run_pat(0, 2, 5, 7, 0, 2'd3, 2'd2, 16, "R2");
  endtask

  task automatic t_codes();
    halt(0);
    cfg(0, win_w(0, 3), per_w(7, 2'd2, 2'd3, 3'd0));
    run_pat(0, 0, 3, 7, 0, 2'd2, 2'd3, 16, "R3");
    halt(0);
    cfg(0, win_w(0, 3), per_w(7, 2'd3, 2'd1, 3'd0));
    run_pat(0, 0, 3, 7, 0, 2'd3, 2'd1, 16, "R3");
  endtask

  task automatic t_presc();
    halt(0);
    cfg(0, win_w(0, 2), per_w(3, 2'd3, 2'd2, 3'd2));
    run_pat(0, 0, 2, 3, 2, 2'd3, 2'd2, 48, "R4");
    halt(0);
    cfg(0, win_w(0, 1), per_w(1, 2'd3, 2'd2, 3'd5));
    run_pat(0, 0, 1, 1, 6, 2'd3, 2'd2, 256, "R4");
    halt(0);
    cfg(0, win_w(0, 1), per_w(1, 2'd3, 2'd2, 3'd7));
    run_pat(0, 0, 1, 1, 10, 2'd3, 2'd2, 2100, "R4");
  endtask

  task automatic t_extremes();
    halt(0);
    cfg(0, win_w(0, 0), per_w(5, 2'd3, 2'd2, 3'd0));
    run_pat(0, 0, 0, 5, 0, 2'd3, 2'd2, 12, "R7");
    halt(0);
    cfg(0, win_w(0, 9), per_w(5, 2'd3, 2'd2, 3'd0));
    run_pat(0, 0, 9, 5, 0, 2'd3, 2'd2, 12, "R7");
  endtask

  task automatic t_shadow();
    halt(0);
    cfg(0, win_w(0, 3), per_w(7, 2'd3, 2'd2, 3'd0));
    @(negedge clk);
    for (int k = 0; k < 48; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 0) ch_en[0] = 1'b1;
      wr_ch = '0;
      wr_active = (k == 2);
      wr_period = (k == 26);
      if (k == 2)  wr_data = win_w(0, 6);
      if (k == 26) wr_data = per_w(7, 2'd3, 2'd2, 3'd0);
      #1;
      if (k < 27)      chk(0, ((k % 8) < 3) ? 2'b11 : 2'b10, "R5");
      else if (k < 32) chk(0, ((k % 8) < 3) ? 2'b11 : 2'b10, "R6");
      else             chk(0, ((k % 8) < 6) ? 2'b11 : 2'b10, "R6");
    end
    @(negedge clk);
    wr_active = 1'b0; wr_period = 1'b0;
  endtask

  task automatic t_isolate();
    halt(0);
    cfg(0, win_w(0, 3), per_w(7, 2'd3, 2'd2, 3'd0));
    @(negedge clk);
    wr_ch = CHW'(1); wr_data = per_w(7, 2'd3, 2'd3, 3'd0); wr_period = 1'b1;
    @(negedge clk);
    wr_period = 1'b0;
    @(negedge clk);
    #1;
    chk(1, 2'b11, "R10");
    chk(0, 2'b10, "R10");
    chk(2, 2'b00, "R10");
  endtask

  initial begin
    #(8 * 200000);
    bad_n++;
    $display("FAIL watchdog (all requirements) got still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1 t_reset();
    t_basic();
    t_window();
    t_codes();
    t_presc();
    t_extremes();
    t_shadow();
    t_isolate();
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end
endmodule